// File: doc/BRIEF.md
# Timer Interrupt and Event Router

This block sits beside a MAC-style timer that has a base counter and an overflow counter. It takes eight single-cycle event strobes from that timer: base overflow, two base compares, overflow-counter wrap, two overflow-counter compares and two long compares. Each strobe sets a sticky flag bit. A per-source enable mask decides which flags drive one shared interrupt request.

Independently of the flags and the mask, two event outputs each forward one chosen strobe as a one-cycle pulse. These outputs are intended to trigger DMA channels or the radio.

Software reaches the block through a small synchronous register port:
- Address 0 holds the flags, which are cleared by writing ones.
- Address 1 holds the mask.
- Address 2 holds the two 4-bit route selects.

Top module: `tev_router`

## Requirements
- R1: Strobe bit positions are 0 base overflow, 1 base compare A, 2 base compare B, 3 overflow-counter wrap, 4 overflow-counter compare A, 5 overflow-counter compare B, 6 long compare A, 7 long compare B. A strobe high at a clock edge sets the matching flag bit after that edge. The bit then stays set until software clears it.
- R2: A flag bit sets and holds even while its mask bit is 0.
- R3: A write to address 0 clears exactly the flag bits written as 1. Bits written as 0 keep their value. No other write or read changes a flag.
- R4: When a strobe and a clear of the same bit meet in one cycle, the bit ends set.
- R5: `irq` is high in the cycle after any bit is set in both the flags and the mask (address 1), and low otherwise.
- R6: Route select A is address 2 bits [3:0]; route select B is address 2 bits [7:4]. A code from 0 to 7 makes that event output pulse high for exactly the cycle after the edge where the numbered strobe was high.
- R7: A route select code from 8 to 15 holds its event output low whatever the strobes do.
- R8: The two event outputs are routed independently. One strobe may drive both outputs, or each output may follow a different strobe.
- R9: `reg_rdata` shows, one cycle after the address is presented, the register at that address as it was before that edge. Address 0 gives the flags, address 1 the mask, address 2 the route selects, and address 3 reads 0.
- R10: After synchronous reset the flags and the mask are 0, both route selects are 15, and `irq`, `evt_out` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 8 | Timer event strobes, one bit per source |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |
| evt_out | output | 2 | Event pulses; bit 0 uses route A, bit 1 uses route B |

## Verification
Strobes are applied one bit at a time, in groups, and together with clears of the same and of other bits. This separates sticky setting, write-one-to-clear selectivity and set priority. The mask is swept with flags both inside and outside it, which shows that the interrupt depends on the mask while flag latching does not. Every route code 0 to 7 is tried against strobes on matching and non-matching bits, and out-of-range codes are tried too. Finally the two routes are set both equal and different, so any swapped bit order, cross-wired output or leaking invalid code shows up on the event pins.

// File: rtl/tev_pkg.sv
package tev_pkg;
  typedef enum logic [1:0] {
    RS_FLAG = 2'd0,
    RS_MASK = 2'd1,
    RS_ROUTE = 2'd2,
    RS_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tev_flag_bank.sv
module tev_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we,
  input  logic [N-1:0] mask_d,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, mask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      // set dominates clear
      flag_q <= (flag_q & ~clr_i) | set_i;
      if (mask_we) mask_q <= mask_d;
      irq_q <= |(flag_q & mask_q);
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_set_sticks_R1: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  assert_hold_without_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ((set_i & clr_i) != '0) |=> ((flag_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));
  assert_irq_high_R5: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & mask_q) != '0) |=> irq_o);
  assert_irq_low_R5: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & mask_q) == '0) |=> !irq_o);
endmodule

// File: rtl/tev_evt_mux.sv
module tev_evt_mux #(
  parameter int N     = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             valid;
  logic [IDX_W-1:0] idx;
  logic             evt_q;

  always_comb begin
    valid = (int'(sel_i) < N);
    idx   = sel_i[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= valid & src_i[idx];
  end

  assign evt_o = evt_q;

  assert_bad_code_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(sel_i) >= N) |=> !evt_o);
  assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |=> !evt_o);
endmodule

// File: rtl/tev_router.sv
module tev_router #(
  parameter int NUM_SRC = 8,
  parameter int NUM_EVT = 2,
  parameter int SEL_W   = 4,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq,
  output logic [NUM_EVT-1:0] evt_out
);
  import tev_pkg::*;

  localparam int ROUTE_W = NUM_EVT * SEL_W;

  logic [NUM_SRC-1:0] flags, mask, clr;
  logic               wr_flag, wr_mask, wr_route;
  logic [ROUTE_W-1:0] route_q;
  logic [NUM_SRC-1:0] rdata_q, rd_mux;

  always_comb begin
    wr_flag  = reg_wr && (reg_addr == ADDR_W'(RS_FLAG));
    wr_mask  = reg_wr && (reg_addr == ADDR_W'(RS_MASK));
    wr_route = reg_wr && (reg_addr == ADDR_W'(RS_ROUTE));
    clr      = wr_flag ? reg_wdata : '0;
  end

  tev_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (src_pulse),
    .clr_i  (clr),
    .mask_we(wr_mask),
    .mask_d (reg_wdata),
    .flag_o (flags),
    .mask_o (mask),
    .irq_o  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)           route_q <= '1;
    else if (wr_route) route_q <= ROUTE_W'(reg_wdata);
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    tev_evt_mux #(.N(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .clk  (clk),
      .rst  (rst),
      .src_i(src_pulse),
      .sel_i(route_q[e*SEL_W +: SEL_W]),
      .evt_o(evt_out[e])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(RS_FLAG))       rd_mux = flags;
    else if (reg_addr == ADDR_W'(RS_MASK))  rd_mux = mask;
    else if (reg_addr == ADDR_W'(RS_ROUTE)) rd_mux = NUM_SRC'(route_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  assert_reserved_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(RS_RSVD)) |=> (reg_rdata == '0));
  assert_route_kept_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_route |=> $stable(route_q));
endmodule

// File: tb/test_tev_router.sv
module test_tev_router;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_pulse = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic [1:0] evt_out;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R10";
  bit done = 0;

  // behavioural model state
  logic [7:0] m_flag, m_mask, m_rd;
  int         m_sel[2];
  logic       m_irq;
  logic [1:0] m_evt;

  always #10 clk = ~clk;

  tev_router i_tev_router (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .evt_out(evt_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_flag = 0; m_mask = 0; m_sel[0] = 15; m_sel[1] = 15;
      m_irq = 0; m_evt = 0; m_rd = 0;
    end else begin
      logic       n_irq;
      logic [1:0] n_evt;
      logic [7:0] n_rd;
      n_irq = (m_flag & m_mask) != 0;
      for (int e = 0; e < 2; e++)
        n_evt[e] = (m_sel[e] < 8) ? src_pulse[m_sel[e]] : 1'b0;
      case (reg_addr)
        2'd0: n_rd = m_flag;
        2'd1: n_rd = m_mask;
        2'd2: n_rd = 8'((m_sel[1] << 4) | m_sel[0]);
        default: n_rd = 0;
      endcase
      if (reg_wr && reg_addr == 2'd0) m_flag = m_flag & ~reg_wdata;
      m_flag = m_flag | src_pulse;
      if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata;
      if (reg_wr && reg_addr == 2'd2) begin
        m_sel[0] = int'(reg_wdata[3:0]);
        m_sel[1] = int'(reg_wdata[7:4]);
      end
      m_irq = n_irq; m_evt = n_evt; m_rd = n_rd;
    end
  end

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  // compare outputs of the last edge, then drive the next inputs
  task automatic step(input logic [7:0] s, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    check("irq", 8'(irq), 8'(m_irq));
    check("evt_out", 8'(evt_out), 8'(m_evt));
    check("reg_rdata", reg_rdata, m_rd);
    src_pulse = s; reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(input logic [1:0] a);
    step(0, 0, a, 0);
    step(0, 0, a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset values
    cur_tag = "R10";
    check("irq after reset", 8'(irq), 8'h00);
    check("evt after reset", 8'(evt_out), 8'h00);
    rd(0); rd(1); rd(2);
    check("route select reset", reg_rdata, 8'hFF);

    // R1 / R2: strobes latch with mask 0
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 0, 0, 0);
      rd(0);
    end
    check("all flags latched unmasked", reg_rdata, 8'hFF);
    cur_tag = "R1";
    step(0, 1, 0, 8'hFF);
    step(8'h24, 0, 0, 0);
    step(0, 0, 0, 0);
    rd(0);
    check("sticky flags", reg_rdata, 8'h24);

    // R5 mask gating of irq
    cur_tag = "R5";
    step(0, 1, 1, 8'h01); rd(0);
    step(0, 1, 1, 8'h04); rd(1);
    step(0, 1, 1, 8'hDB); rd(0);
    step(0, 1, 1, 8'h20); rd(1);

    // R3 write-one-to-clear
    cur_tag = "R3";
    step(0, 1, 1, 8'h00);
    step(8'hF0, 0, 0, 0);
    step(0, 1, 0, 8'h30); rd(0);
    step(0, 1, 0, 8'h00); rd(0);
    step(0, 1, 1, 8'h0F); rd(0);
    step(0, 1, 2, 8'hFF); rd(0);

    // R4 set beats clear
    cur_tag = "R4";
    step(8'h81, 1, 0, 8'hFF); rd(0);
    step(8'h02, 1, 0, 8'h81); rd(0);

    // R6 every valid code
    cur_tag = "R6";
    for (int c = 0; c < 8; c++) begin
      step(0, 1, 2, 8'((c << 4) | c));
      for (int b = 0; b < 8; b++) step(8'(1 << b), 0, 0, 0);
      step(8'hFF, 0, 0, 0);
      step(0, 0, 2, 0);
    end

    // R7 invalid codes
    cur_tag = "R7";
    step(0, 1, 2, 8'hF8);
    step(8'hFF, 0, 0, 0);
    step(8'h01, 0, 0, 0);
    step(0, 1, 2, 8'h9C);
    step(8'hFF, 0, 0, 0);
    step(0, 0, 0, 0);

    // R8 independent routes
    cur_tag = "R8";
    step(0, 1, 2, 8'h52);
    step(8'h04, 0, 0, 0);
    step(8'h20, 0, 0, 0);
    step(8'h24, 0, 0, 0);
    step(0, 1, 2, 8'h33);
    step(8'h08, 0, 0, 0);
    step(0, 0, 0, 0);

    // R9 reads incl. reserved address
    cur_tag = "R9";
    rd(3); rd(2); rd(1); rd(0);
    step(0, 0, 3, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule